// File: doc/BRIEF.md
# Dual-Byte Latched Bidirectional Transceiver

This block joins two 16-bit buses, called side A and side B, through two byte lanes that are controlled separately. Each lane has two storage banks, one carrying data from A toward B and one carrying data from B toward A. Each direction of each lane has three active-low controls of its own: a chip enable, a latch enable and a drive enable. The bank is open, which means it follows its input, while chip enable and latch enable are both low. When either of them goes high, the bank keeps what it last took in. The destination side is driven only while chip enable and drive enable are both low.

The pins are split into separate input, output and output-enable vectors so that the block can be synthesized. Each input bit also has a "driven" flag. When bus hold is enabled, a bit whose driver has let go keeps the last value it carried and does not float. Storage updates on the clock. An open bank also passes its input straight to the output within the same cycle. Each bank follows a two-state machine. In state LS_PASS the bank is open. In state LS_STORE it keeps its value. The machine moves from LS_PASS to LS_STORE when the effective enable (chip enable OR latch enable) goes high, and from LS_STORE back to LS_PASS when both controls go low.

Top module: `dbt_transceiver`

## Requirements
- R1: After reset, every stored bank and every bus-hold register is zero, and with all controls high no output is driven: all `*_oe` bits and all `*_out` bits are 0, and every `contention` bit is 0.
- R2: While a lane's A-to-B chip enable and latch enable are both low and its drive enable is low, that lane's `b_out` equals the effective A input of the lane in the same cycle.
- R3: When a lane's A-to-B latch enable is high, its `b_out` keeps showing the A input sampled at the last clock edge at which chip enable and latch enable were both low. Later changes on A have no effect.
- R4: While a lane's A-to-B chip enable is high, the bank keeps its contents whatever the latch enable and A do. This is visible once chip enable returns low with latch enable high.
- R5: A lane's `b_oe` bits are all 1 exactly when that lane's A-to-B chip enable and drive enable are both low, and are all 0 otherwise. While they are 0, that lane's `b_out` is 0.
- R6: The B-to-A direction follows R2 to R5 with its own three controls, taking data from side B and producing `a_out` and `a_oe`.
- R7: Lane 0 (bits 7:0) and lane 1 (bits 15:8) are independent. Controls and data of one lane never change the outputs of the other lane.
- R8: With BUS_HOLD=1, an input bit whose driven flag is 0 reads as the value that bit last had at a clock edge while its flag was 1 (0 since reset).
- R9: `contention[h]` is 1 exactly when lane h drives side A and side B at the same time. Each side then carries its own bank's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for storage updates |
| rst_n | input | 1 | Active-low synchronous reset |
| ab_chip_en_n | input | 2 | Per-lane A-to-B chip enable, active low |
| ab_latch_en_n | input | 2 | Per-lane A-to-B latch enable, active low (low = open) |
| ab_drive_en_n | input | 2 | Per-lane A-to-B drive enable, active low |
| ba_chip_en_n | input | 2 | Per-lane B-to-A chip enable, active low |
| ba_latch_en_n | input | 2 | Per-lane B-to-A latch enable, active low |
| ba_drive_en_n | input | 2 | Per-lane B-to-A drive enable, active low |
| a_in | input | 16 | Value seen on side A pins |
| a_drv | input | 16 | Per-bit flag: side A bit is driven externally |
| a_out | output | 16 | Value driven onto side A |
| a_oe | output | 16 | Per-bit output enable for side A |
| b_in | input | 16 | Value seen on side B pins |
| b_drv | input | 16 | Per-bit flag: side B bit is driven externally |
| b_out | output | 16 | Value driven onto side B |
| b_oe | output | 16 | Per-bit output enable for side B |
| contention | output | 2 | Per-lane flag: both sides driven at once |

## Verification
The bench uses the default build: two lanes of eight bits each, with bus hold enabled. With this small configuration, all 64 combinations of one lane's six control bits can be swept in turn for each lane, while the other lane stays idle and its outputs are checked to stay quiet. Bench-side models of the banks and hold registers predict every output. Targeted sequences then cover storage, chip-enable holding, lanes with different controls, floating bits and contention.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
    typedef enum logic {
        LS_PASS  = 1'b0,
        LS_STORE = 1'b1
    } latch_state_t;
endpackage

// File: rtl/dbt_hold.sv
module dbt_hold #(
    parameter int W       = 8,
    parameter bit HOLD_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] drv,
    output logic [W-1:0] eff
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= (pin & drv) | (held_q & ~drv);
    end

    generate
        if (HOLD_EN) begin : g_hold
            assign eff = (pin & drv) | (held_q & ~drv);
        end else begin : g_nohold
            assign eff = pin & drv;
        end
    endgenerate

    // R8: a fully floating input keeps a steady value
    p_float_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drv == '0 && $past(drv) == '0) |-> $stable(eff));
endmodule

// File: rtl/dbt_path.sv
module dbt_path
    import dbt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chip_en_n,
    input  logic         latch_en_n,
    input  logic         drive_en_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] doe,
    output logic         out_en
);
    latch_state_t state_q, state_nxt;
    logic [W-1:0] data_q;
    logic         open_now;
    logic [W-1:0] latch_val;

    assign open_now = !chip_en_n && !latch_en_n;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            LS_PASS:  state_nxt = open_now ? LS_PASS : LS_STORE;
            LS_STORE: state_nxt = open_now ? LS_PASS : LS_STORE;
            default:  state_nxt = LS_STORE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_STORE;
            data_q  <= '0;
        end else begin
            state_q <= state_nxt;
            if (state_nxt == LS_PASS) data_q <= din;
        end
    end

    always_comb begin
        latch_val = open_now ? din : data_q;
        out_en    = !chip_en_n && !drive_en_n;
        dout      = out_en ? latch_val : '0;
        doe       = {W{out_en}};
    end

    // R2: an open, driving bank passes its input straight through
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en_n && !latch_en_n && !drive_en_n) |-> (dout == din));
    // R3: a closed bank keeps its value across cycles
    p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_STORE && !open_now) |-> $stable(latch_val));
    // R4: chip enable high freezes the bank whatever latch enable does
    p_chip_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en_n && $past(chip_en_n)) |-> $stable(latch_val));
    // R5: no drive unless both enables are low
    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en_n || drive_en_n) |-> (doe == '0 && dout == '0));
endmodule

// File: rtl/dbt_half.sv
module dbt_half #(
    parameter int W        = 8,
    parameter bit BUS_HOLD = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ab_chip_en_n,
    input  logic         ab_latch_en_n,
    input  logic         ab_drive_en_n,
    input  logic         ba_chip_en_n,
    input  logic         ba_latch_en_n,
    input  logic         ba_drive_en_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_drv,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] b_drv,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic         contention
);
    logic [W-1:0] a_eff, b_eff;
    logic         ab_on, ba_on;

    dbt_hold #(.W(W), .HOLD_EN(BUS_HOLD)) u_hold_a (
        .clk(clk), .rst_n(rst_n), .pin(a_in), .drv(a_drv), .eff(a_eff));
    dbt_hold #(.W(W), .HOLD_EN(BUS_HOLD)) u_hold_b (
        .clk(clk), .rst_n(rst_n), .pin(b_in), .drv(b_drv), .eff(b_eff));

    dbt_path #(.W(W)) u_ab (
        .clk(clk), .rst_n(rst_n),
        .chip_en_n(ab_chip_en_n), .latch_en_n(ab_latch_en_n), .drive_en_n(ab_drive_en_n),
        .din(a_eff), .dout(b_out), .doe(b_oe), .out_en(ab_on));
    dbt_path #(.W(W)) u_ba (
        .clk(clk), .rst_n(rst_n),
        .chip_en_n(ba_chip_en_n), .latch_en_n(ba_latch_en_n), .drive_en_n(ba_drive_en_n),
        .din(b_eff), .dout(a_out), .doe(a_oe), .out_en(ba_on));

    assign contention = ab_on && ba_on;

    // R9: the flag marks both sides driven together
    p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        contention |-> ((&a_oe) && (&b_oe)));
    p_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !contention |-> !((|a_oe) && (|b_oe)));
endmodule

// File: rtl/dbt_transceiver.sv
module dbt_transceiver #(
    parameter int LANE_W   = 8,
    parameter int NLANE    = 2,
    parameter bit BUS_HOLD = 1'b1,
    localparam int BUS_W   = LANE_W * NLANE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLANE-1:0] ab_chip_en_n,
    input  logic [NLANE-1:0] ab_latch_en_n,
    input  logic [NLANE-1:0] ab_drive_en_n,
    input  logic [NLANE-1:0] ba_chip_en_n,
    input  logic [NLANE-1:0] ba_latch_en_n,
    input  logic [NLANE-1:0] ba_drive_en_n,
    input  logic [BUS_W-1:0] a_in,
    input  logic [BUS_W-1:0] a_drv,
    output logic [BUS_W-1:0] a_out,
    output logic [BUS_W-1:0] a_oe,
    input  logic [BUS_W-1:0] b_in,
    input  logic [BUS_W-1:0] b_drv,
    output logic [BUS_W-1:0] b_out,
    output logic [BUS_W-1:0] b_oe,
    output logic [NLANE-1:0] contention
);
    generate
        for (genvar h = 0; h < NLANE; h++) begin : g_lane
            dbt_half #(.W(LANE_W), .BUS_HOLD(BUS_HOLD)) u_half (
                .clk(clk), .rst_n(rst_n),
                .ab_chip_en_n(ab_chip_en_n[h]), .ab_latch_en_n(ab_latch_en_n[h]),
                .ab_drive_en_n(ab_drive_en_n[h]),
                .ba_chip_en_n(ba_chip_en_n[h]), .ba_latch_en_n(ba_latch_en_n[h]),
                .ba_drive_en_n(ba_drive_en_n[h]),
                .a_in(a_in[h*LANE_W +: LANE_W]), .a_drv(a_drv[h*LANE_W +: LANE_W]),
                .a_out(a_out[h*LANE_W +: LANE_W]), .a_oe(a_oe[h*LANE_W +: LANE_W]),
                .b_in(b_in[h*LANE_W +: LANE_W]), .b_drv(b_drv[h*LANE_W +: LANE_W]),
                .b_out(b_out[h*LANE_W +: LANE_W]), .b_oe(b_oe[h*LANE_W +: LANE_W]),
                .contention(contention[h]));
        end
    endgenerate
endmodule

// File: tb/dbt_transceiver_bench.sv
module dbt_transceiver_bench;
    localparam int P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  ab_ce, ab_le, ab_oe, ba_ce, ba_le, ba_oe;
    logic [15:0] a_in, a_drv, b_in, b_drv;
    logic [15:0] a_out, a_oe, b_out, b_oe;
    logic [1:0]  contention;
    int          errs = 0;
    int          checks = 0;

    always #(P/2) clk = ~clk;

    dbt_transceiver u_dbt_transceiver (
        .clk(clk), .rst_n(rst_n),
        .ab_chip_en_n(ab_ce), .ab_latch_en_n(ab_le), .ab_drive_en_n(ab_oe),
        .ba_chip_en_n(ba_ce), .ba_latch_en_n(ba_le), .ba_drive_en_n(ba_oe),
        .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe),
        .contention(contention));

    // bench-side model of hold registers and banks
    logic [15:0] ha, hb, ea, eb;
    logic [7:0]  rab [2];
    logic [7:0]  rba [2];
    assign ea = (a_in & a_drv) | (ha & ~a_drv);
    assign eb = (b_in & b_drv) | (hb & ~b_drv);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ha <= '0; hb <= '0;
            for (int h = 0; h < 2; h++) begin rab[h] <= '0; rba[h] <= '0; end
        end else begin
            ha <= ea; hb <= eb;
            for (int h = 0; h < 2; h++) begin
                if (!ab_ce[h] && !ab_le[h]) rab[h] <= ea[h*8 +: 8];
                if (!ba_ce[h] && !ba_le[h]) rba[h] <= eb[h*8 +: 8];
            end
        end
    end

    task automatic check(input string tag);
        logic [65:0] act, exp;
        logic [15:0] xb, xbo, xa, xao;
        logic [1:0]  xc;
        for (int h = 0; h < 2; h++) begin
            logic on_ab, on_ba;
            logic [7:0] vab, vba;
            vab = (!ab_ce[h] && !ab_le[h]) ? ea[h*8 +: 8] : rab[h];
            vba = (!ba_ce[h] && !ba_le[h]) ? eb[h*8 +: 8] : rba[h];
            on_ab = !ab_ce[h] && !ab_oe[h];
            on_ba = !ba_ce[h] && !ba_oe[h];
            xb[h*8 +: 8]  = on_ab ? vab : 8'h00;
            xbo[h*8 +: 8] = {8{on_ab}};
            xa[h*8 +: 8]  = on_ba ? vba : 8'h00;
            xao[h*8 +: 8] = {8{on_ba}};
            xc[h] = on_ab && on_ba;
        end
        act = {b_out, b_oe, a_out, a_oe, contention};
        exp = {xb, xbo, xa, xao, xc};
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        #1;
        check(tag);
        @(negedge clk);
    endtask

    task automatic idle_all();
        ab_ce = '1; ab_le = '1; ab_oe = '1;
        ba_ce = '1; ba_le = '1; ba_oe = '1;
    endtask

    initial begin
        #(P * 200000);
        errs++; checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle_all();
        a_in = '0; b_in = '0; a_drv = '0; b_drv = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, nothing driven
        step("R1");
        step("R1");

        // R5: sweep every control combination on each lane, other lane idle
        a_drv = '1; b_drv = '1;
        for (int h = 0; h < 2; h++) begin
            for (int c = 0; c < 64; c++) begin
                idle_all();
                ab_ce[h] = c[0]; ab_le[h] = c[1]; ab_oe[h] = c[2];
                ba_ce[h] = c[3]; ba_le[h] = c[4]; ba_oe[h] = c[5];
                a_in = 16'((c * 37 + 5) * 257);
                b_in = 16'((c * 91 + 11) * 129);
                step("R5");
            end
        end

        // R2: lane 0 open A-to-B, several data patterns
        idle_all();
        ab_ce[0] = 0; ab_le[0] = 0; ab_oe[0] = 0;
        for (int k = 0; k < 6; k++) begin
            a_in = 16'(k * 4111 + 3);
            step("R2");
        end

        // R3: close with latch enable, then change A
        ab_le[0] = 1;
        for (int k = 0; k < 5; k++) begin
            a_in = 16'(k * 2221 + 77);
            step("R3");
        end

        // R4: chip enable high, toggle latch enable and A, then look
        ab_ce[0] = 1;
        for (int k = 0; k < 4; k++) begin
            ab_le[0] = k[0];
            a_in = 16'(k * 999 + 1);
            step("R4");
        end
        ab_le[0] = 1; ab_ce[0] = 0;
        step("R4");

        // R6: lane 1 B-to-A open then stored
        idle_all();
        ba_ce[1] = 0; ba_le[1] = 0; ba_oe[1] = 0;
        for (int k = 0; k < 4; k++) begin
            b_in = 16'(k * 3333 + 9);
            step("R6");
        end
        ba_le[1] = 1;
        for (int k = 0; k < 4; k++) begin
            b_in = 16'(k * 1717 + 2);
            step("R6");
        end

        // R7: lanes with different control patterns at once
        idle_all();
        ab_ce[0] = 0; ab_le[0] = 0; ab_oe[0] = 0;
        ba_ce[1] = 0; ba_le[1] = 1; ba_oe[1] = 0;
        for (int k = 0; k < 6; k++) begin
            a_in = 16'(k * 5153 + 21);
            b_in = 16'(k * 6007 + 13);
            step("R7");
        end

        // R8: release some A bits while lane 0 is open
        a_in = 16'hA5C3;
        step("R8");
        a_drv = 16'hF00F;
        a_in = 16'h0000;
        step("R8");
        a_in = 16'hFFFF;
        step("R8");
        a_drv = 16'h0000;
        a_in = 16'h1234;
        step("R8");
        step("R8");
        a_drv = 16'hFFFF;

        // R9: both directions of lane 0 driven together
        idle_all();
        ab_ce[0] = 0; ab_le[0] = 0; ab_oe[0] = 0;
        ba_ce[0] = 0; ba_le[0] = 0; ba_oe[0] = 0;
        a_in = 16'h3C5A; b_in = 16'h96E1;
        step("R9");
        ba_oe[0] = 1;
        step("R9");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule